// File: doc/BRIEF.md
# Translator Configuration Register Bank

This block holds the two 64-bit registers that set up an address translator: a control word and a table-base word. It exposes them on a small request/response slave port and drives their current values continuously to the translator. A bus master may reach each register as one 8-byte word. It may also reach it as two 4-byte halves in big-endian order, where the lower address holds the upper half. A third, two-word slot serves as a flush location that has no effect on writes and reads as zero. All other offsets are also harmless.

Requests use a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A write changes the register on that edge and returns nothing. A read returns its data one cycle later under `rsp_valid`. The response is held, with stable data, until `rsp_ready` is high. While a response waits for `rsp_ready`, `req_ready` is low, so back-pressure on the response stalls new requests.

Top module: `xlat_cfg_regs`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) sets both registers to zero, leaves `rsp_valid` low and `req_ready` high.
- R2: An 8-byte access (`req_wide`=1) at offset 0x00 (control) or 0x08 (table base) writes all 64 bits from `req_wdata` or reads all 64 bits into `rsp_rdata`.
- R3: A 4-byte access (`req_wide`=0) at offset 0x00 or 0x08 acts on bits 63:32 only. A write loads them from `req_wdata[31:0]` and keeps bits 31:0. A read returns them in `rsp_rdata[31:0]`.
- R4: Any access at offset 0x04 or 0x0C, of either size, acts on bits 31:0 only. A write loads them from `req_wdata[31:0]` and keeps bits 63:32. A read returns them in `rsp_rdata[31:0]`.
- R5: Every read that returns a half register has `rsp_rdata[63:32]` equal to zero.
- R6: Writes to the flush offsets 0x10 and 0x14 change no register, and reads from them return zero.
- R7: Every other offset, unaligned ones included, reads as zero, and writes to it change no register.
- R8: A write accepted on a clock edge shows on `ctrl_q` / `tbase_q` right after that same edge.
- R9: An accepted read raises `rsp_valid` after the next edge. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold, `req_ready` is low, and no request is accepted.
- R10: An accepted write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_wdata | input | DATA_W | Write data; 4-byte writes use bits 31:0 |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | DATA_W | Read data; half reads use bits 31:0 |
| ctrl_q | output | DATA_W | Current control register |
| tbase_q | output | DATA_W | Current table-base register |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 64-bit word, control at 0x00 and table base at 0x08. The flush slot sits at 0x10 in this build. The 8-bit address reaches past the flush slot (0x18, 0x20) and reaches unaligned offsets, so the unimplemented region can be probed as well as every half of both registers. The distinct upper and lower halves written into each register show at once whether a partial write has disturbed the other half.

// File: rtl/xlat_cfg_pkg.sv
package xlat_cfg_pkg;

  // Which part of a register one access touches.
  typedef enum logic [1:0] {
    LANE_NONE = 2'd0,
    LANE_FULL = 2'd1,
    LANE_HI   = 2'd2,
    LANE_LO   = 2'd3
  } lane_e;

  // Byte distance between the upper-half and lower-half slots of a word.
  localparam int HALF_BYTES = 4;

endpackage

// File: rtl/xlat_cfg_decode.sv
module xlat_cfg_decode
  import xlat_cfg_pkg::*;
#(
  parameter int                    ADDR_W = 8,
  parameter int                    NREG   = 2,
  parameter logic [NREG*ADDR_W-1:0] OFFS  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output lane_e             lane_o [NREG]
);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] OFF_HI = OFFS[i*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] OFF_LO = OFF_HI + ADDR_W'(HALF_BYTES);

    always_comb begin
      if (addr == OFF_HI)      lane_o[i] = wide ? LANE_FULL : LANE_HI;
      else if (addr == OFF_LO) lane_o[i] = LANE_LO;
      else                     lane_o[i] = LANE_NONE;
    end
  end

endmodule

// File: rtl/xlat_cfg_word.sv
module xlat_cfg_word
  import xlat_cfg_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  lane_e        lane,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] rd_view
);

  localparam int H = W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      case (lane)
        LANE_FULL: q          <= wdata;
        LANE_HI:   q[W-1:H]   <= wdata[H-1:0];
        LANE_LO:   q[H-1:0]   <= wdata[H-1:0];
        default:   ;
      endcase
    end
  end

  // Half reads come back right-aligned with a zero upper half.
  always_comb begin
    case (lane)
      LANE_FULL: rd_view = q;
      LANE_HI:   rd_view = {{H{1'b0}}, q[W-1:H]};
      LANE_LO:   rd_view = {{H{1'b0}}, q[H-1:0]};
      default:   rd_view = '0;
    endcase
  end

endmodule

// File: rtl/xlat_cfg_rsp.sv
module xlat_cfg_rsp #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] data,
  input  logic         rsp_ready,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
  import xlat_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 64,
  parameter logic [ADDR_W-1:0] CTRL_OFF  = 8'h00,
  parameter logic [ADDR_W-1:0] BASE_OFF  = 8'h08,
  parameter logic [ADDR_W-1:0] FLUSH_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] tbase_q
);

  localparam int NREG = 2;
  localparam logic [NREG*ADDR_W-1:0] OFFS = {BASE_OFF, CTRL_OFF};

  logic              fire, wr_fire, rd_fire;
  lane_e             lanes   [NREG];
  logic [DATA_W-1:0] word_q  [NREG];
  logic [DATA_W-1:0] word_rd [NREG];
  logic [DATA_W-1:0] rd_mux;

  // A held response blocks new requests; the flush slot and any other
  // offset simply fall outside the decode and act as nothing.
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;

  xlat_cfg_decode #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .OFFS   (OFFS)
  ) u_dec (
    .addr   (req_addr),
    .wide   (req_wide),
    .lane_o (lanes)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_word
    xlat_cfg_word #(.W(DATA_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_fire),
      .lane    (lanes[i]),
      .wdata   (req_wdata),
      .q       (word_q[i]),
      .rd_view (word_rd[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) rd_mux |= word_rd[i];
  end

  xlat_cfg_rsp #(.W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_fire),
    .data      (rd_mux),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign ctrl_q  = word_q[0];
  assign tbase_q = word_q[1];

endmodule

// File: rtl/xlat_cfg_regs_chk.sv
module xlat_cfg_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 64,
  parameter logic [ADDR_W-1:0] CTRL_OFF  = 8'h00,
  parameter logic [ADDR_W-1:0] BASE_OFF  = 8'h08,
  parameter logic [ADDR_W-1:0] FLUSH_OFF = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_wide,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] tbase_q
);

  localparam int H = DATA_W / 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic acc, acc_wr, acc_rd, hits_reg;
  assign acc    = req_valid && req_ready;
  assign acc_wr = acc && req_write;
  assign acc_rd = acc && !req_write;
  assign hits_reg = (req_addr == CTRL_OFF) || (req_addr == CTRL_OFF + STEP) ||
                    (req_addr == BASE_OFF) || (req_addr == BASE_OFF + STEP);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (ctrl_q == '0 && tbase_q == '0 && !rsp_valid));

  assert_wide_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_wide && req_addr == CTRL_OFF) |=> ctrl_q == $past(req_wdata));

  assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !req_wide && req_addr == CTRL_OFF)
      |=> ctrl_q[H-1:0] == $past(ctrl_q[H-1:0]));

  assert_lo_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr == BASE_OFF + STEP)
      |=> tbase_q[DATA_W-1:H] == $past(tbase_q[DATA_W-1:H]));

  assert_half_read_zero_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !req_wide) |=> rsp_rdata[DATA_W-1:H] == '0);

  assert_flush_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && (req_addr == FLUSH_OFF || req_addr == FLUSH_OFF + STEP))
      |=> rsp_rdata == '0);

  assert_stray_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !hits_reg) |=> ($stable(ctrl_q) && $stable(tbase_q)));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_no_write_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc_rd));

endmodule

bind xlat_cfg_regs xlat_cfg_regs_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CTRL_OFF  (CTRL_OFF),
  .BASE_OFF  (BASE_OFF),
  .FLUSH_OFF (FLUSH_OFF)
) u_chk (.*);

// File: tb/xlat_cfg_regs_test.sv
module xlat_cfg_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic [63:0] ctrl_q, tbase_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  xlat_cfg_regs uut (.*);

  typedef struct packed {
    logic [7:0]  addr;
    logic        wr;
    logic        wide;
    logic [63:0] wdata;
    logic [63:0] exp_rd;
    logic [63:0] exp_ctrl;
    logic [63:0] exp_tbase;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2: whole-word write and read of control
    '{8'h00, 1'b1, 1'b1, 64'h0123456789ABCDEF, 64'h0, 64'h0123456789ABCDEF, 64'h0},
    '{8'h00, 1'b0, 1'b1, 64'h0, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF, 64'h0},
    // R3: upper half write, then upper half read (R5 zero top)
    '{8'h00, 1'b1, 1'b0, 64'hFFFFFFFFAAAA5555, 64'h0, 64'hAAAA555589ABCDEF, 64'h0},
    '{8'h00, 1'b0, 1'b0, 64'h0, 64'h00000000AAAA5555, 64'hAAAA555589ABCDEF, 64'h0},
    // R4: lower half write; wide read at +4 still gives lower half only
    '{8'h04, 1'b1, 1'b0, 64'h0000000013572468, 64'h0, 64'hAAAA555513572468, 64'h0},
    '{8'h04, 1'b0, 1'b1, 64'h0, 64'h0000000013572468, 64'hAAAA555513572468, 64'h0},
    // R2: table base whole write; R4 lower half read
    '{8'h08, 1'b1, 1'b1, 64'hFEDCBA9876543210, 64'h0, 64'hAAAA555513572468, 64'hFEDCBA9876543210},
    '{8'h0C, 1'b0, 1'b0, 64'h0, 64'h0000000076543210, 64'hAAAA555513572468, 64'hFEDCBA9876543210},
    // R3: table base upper half write
    '{8'h08, 1'b1, 1'b0, 64'h000000000000BEEF, 64'h0, 64'hAAAA555513572468, 64'h0000BEEF76543210},
    // R6: flush slot
    '{8'h10, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'hAAAA555513572468, 64'h0000BEEF76543210},
    '{8'h14, 1'b0, 1'b0, 64'h0, 64'h0, 64'hAAAA555513572468, 64'h0000BEEF76543210},
    '{8'h10, 1'b0, 1'b1, 64'h0, 64'h0, 64'hAAAA555513572468, 64'h0000BEEF76543210},
    // R7: unaligned and out-of-range offsets
    '{8'h02, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'hAAAA555513572468, 64'h0000BEEF76543210},
    '{8'h18, 1'b0, 1'b1, 64'h0, 64'h0, 64'hAAAA555513572468, 64'h0000BEEF76543210},
    '{8'h20, 1'b1, 1'b0, 64'h00000000FFFFFFFF, 64'h0, 64'hAAAA555513572468, 64'h0000BEEF76543210},
    // R2: whole read of table base
    '{8'h08, 1'b0, 1'b1, 64'h0, 64'h0000BEEF76543210, 64'hAAAA555513572468, 64'h0000BEEF76543210}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ctrl", ctrl_q, 64'h0);
    check("R1 tbase", tbase_q, 64'h0);
    check("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", {63'h0, req_ready}, 64'h1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = VECS[i].addr;
      req_write = VECS[i].wr;
      req_wide  = VECS[i].wide;
      req_wdata = VECS[i].wdata;
      @(negedge clk);
      req_valid = 1'b0;
      if (VECS[i].wr) begin
        check($sformatf("R10 vec %0d no response", i), {63'h0, rsp_valid}, 64'h0);
      end else begin
        check($sformatf("R9 vec %0d rsp_valid", i), {63'h0, rsp_valid}, 64'h1);
        check($sformatf("R2-R7 vec %0d rdata", i), rsp_rdata, VECS[i].exp_rd);
      end
      check($sformatf("R8 vec %0d ctrl", i), ctrl_q, VECS[i].exp_ctrl);
      check($sformatf("R8 vec %0d tbase", i), tbase_q, VECS[i].exp_tbase);
    end

    // R9: back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 8'h00; req_write = 1'b0; req_wide = 1'b1;
    @(negedge clk);
    check("R9 held valid", {63'h0, rsp_valid}, 64'h1);
    check("R9 held data", rsp_rdata, 64'hAAAA555513572468);
    check("R9 ready low", {63'h0, req_ready}, 64'h0);
    req_write = 1'b1; req_wdata = 64'h0;  // offered while blocked
    @(negedge clk);
    check("R9 still valid", {63'h0, rsp_valid}, 64'h1);
    check("R9 data stable", rsp_rdata, 64'hAAAA555513572468);
    check("R9 blocked write", ctrl_q, 64'hAAAA555513572468);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 released", {63'h0, rsp_valid}, 64'h0);
    check("R8 write after release", ctrl_q, 64'h0);

    // R1: reset in mid-run clears the table base
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run tbase", tbase_q, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule